// File: doc/BRIEF.md
# CAN Controller Operating-Mode Manager

This block decides which operating mode a CAN protocol engine runs in. It also sits on the bit-level path between that engine and the transceiver pins. It takes control bits for freeze enable, halt, debug request, listen-only, loop-back and disable. It also takes the raw receive pin, the engine's transmit bit, and per-bit frame-position flags from the engine: an ACK-slot marker and a bus-idle marker.

From these inputs it drives the transmit pin, the bit the engine receives, a transmit-enable gate, an error-counter freeze, an error-passive force and a freeze acknowledge. It also passes on the engine's transmit-done and receive-done events as qualified interrupt strobes.

Freeze is taken at once whenever it is allowed and requested. Every other mode change waits for the engine to report bus idle, so a frame is never cut in half. In listen-only operation the block watches the ACK slot itself. In loop-back it makes the engine's own frame look acknowledged.

Top module: `can_mode_mgr`

## Requirements
- R1: When freezeEn is 1 and haltReq or dbgReq is 1 at a rising edge, the mode becomes freeze at that edge, whatever busIdle is. With freezeEn at 0, haltReq and dbgReq change nothing.
- R2: freezeAck is 1 after an edge that leaves the block in freeze, provided busIdle was 1 at that edge or freezeAck was already 1. In every other case it is 0, and it drops at the same edge that leaves freeze.
- R3: In freeze, engHold is 1, txEnable is 0, txPin is 1 and engRxBit is 1. txIrq and rxIrq are 0, and errCntFreeze is 1.
- R4: With no freeze request, the mode changes only at an edge where busIdle is 1. The new mode is chosen in this priority order: disable, then loop-back, then listen-only, then normal.
- R5: In listen-only, txEnable is 0 and txPin is 1 whatever engTxBit is. errCntFreeze and errPassive are both 1.
- R6: In listen-only, bit0Err is 1 whenever ackSlot is 1 and the synchronised receive bit is recessive (1). Otherwise it is 0. errCntFreeze stays 1 while bit0Err is raised.
- R7: In listen-only, txIrq is 0. rxIrq passes rxDone only if the most recent edge with ackSlot=1 sampled a dominant (0) synchronised receive bit.
- R8: In loop-back, engRxBit equals engTxBit and rxPin has no effect. txPin is 1 and txEnable is 1.
- R9: In loop-back, engRxBit is forced to 0 while ackSlot is 1. txIrq follows txDone and rxIrq follows rxDone.
- R10: When both loopBack and listenOnly are set, the block runs in loop-back: the data path loops, txEnable is 1 and txPin stays 1.
- R11: The block comes out of reset in disable. In disable, txPin=1, engRxBit=1, engHold=1, and txEnable, errCntFreeze, errPassive, freezeAck, bit0Err, txIrq and rxIrq are all 0.
- R12: In normal mode, txPin equals engTxBit and txEnable is 1. engRxBit follows rxPin through a two-edge synchroniser. txIrq and rxIrq follow txDone and rxDone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| freezeEn | input | 1 | Allows freeze to be entered |
| haltReq | input | 1 | Halt request from control |
| dbgReq | input | 1 | Debug request from the system |
| listenOnly | input | 1 | Listen-only request |
| loopBack | input | 1 | Loop-back request |
| disableReq | input | 1 | Disable request |
| rxPin | input | 1 | Raw receive pin from transceiver |
| engTxBit | input | 1 | Transmit bit from protocol engine |
| ackSlot | input | 1 | Engine marks the current bit as the ACK slot |
| busIdle | input | 1 | Engine reports a frame boundary or idle bus |
| txDone | input | 1 | Engine transmit-complete event |
| rxDone | input | 1 | Engine receive-complete event |
| txPin | output | 1 | Transmit pin to transceiver |
| engRxBit | output | 1 | Receive bit fed to the engine |
| txEnable | output | 1 | Allows the engine to transmit |
| errCntFreeze | output | 1 | Freezes the engine's error counters |
| errPassive | output | 1 | Forces error-passive behaviour |
| engHold | output | 1 | Holds the engine idle |
| freezeAck | output | 1 | Freeze acknowledge |
| bit0Err | output | 1 | Bit-0 error for an unacknowledged frame in listen-only |
| txIrq | output | 1 | Qualified transmit-complete interrupt |
| rxIrq | output | 1 | Qualified receive-complete interrupt |

## Verification
Different results come due at different times after a stimulus:
- A mode change appears one rising edge after its inputs are applied.
- freezeAck appears on the edge that sees busIdle while in freeze.
- In normal mode, engRxBit trails rxPin by exactly two edges.
- txPin, the loop-back path, bit0Err and the interrupt strobes are combinational on the current mode and settle within the same cycle.

The bench drives every input just after a falling edge. It queues each expectation only after the right number of rising edges has passed, and the monitor reads the outputs a nanosecond later, well away from any edge. The synchroniser is checked one edge early, where it must still show the old value, and again at the second edge.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

  typedef enum logic [2:0] {
    MODE_DIS    = 3'd0,
    MODE_NORM   = 3'd1,
    MODE_LISTEN = 3'd2,
    MODE_LOOP   = 3'd3,
    MODE_FRZ    = 3'd4
  } opMode_e;

  // strobes from control to the bit path
  typedef struct packed {
    logic hold;
    logic loopSel;
    logic ackIgnore;
    logic pinDrive;
    logic listenChk;
    logic txIrqOk;
    logic rxIrqOk;
  } pathStrb_t;

endpackage

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
  import can_mode_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      freezeEn,
  input  logic      haltReq,
  input  logic      dbgReq,
  input  logic      listenOnly,
  input  logic      loopBack,
  input  logic      disableReq,
  input  logic      busIdle,
  output opMode_e   modeQ,
  output pathStrb_t strb,
  output logic      txEnable,
  output logic      errCntFreeze,
  output logic      errPassive,
  output logic      engHold,
  output logic      freezeAck
);

  logic    freezeReq;
  opMode_e targetMode;
  opMode_e nextMode;
  logic    ackQ;

  assign freezeReq = freezeEn & (haltReq | dbgReq);

  // boundary target, highest priority first
  always_comb begin
    if (disableReq)      targetMode = MODE_DIS;
    else if (loopBack)   targetMode = MODE_LOOP;
    else if (listenOnly) targetMode = MODE_LISTEN;
    else                 targetMode = MODE_NORM;
  end

  always_comb begin
    if (freezeReq)    nextMode = MODE_FRZ;
    else if (busIdle) nextMode = targetMode;
    else              nextMode = modeQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= MODE_DIS;
      ackQ  <= 1'b0;
    end else begin
      modeQ <= nextMode;
      ackQ  <= (nextMode == MODE_FRZ) && (busIdle || ackQ);
    end
  end

  assign freezeAck = ackQ;

  // decode of the current mode
  always_comb begin
    strb         = '0;
    txEnable     = 1'b0;
    errCntFreeze = 1'b0;
    errPassive   = 1'b0;
    engHold      = 1'b0;
    unique case (modeQ)
      MODE_NORM: begin
        strb.pinDrive = 1'b1;
        strb.txIrqOk  = 1'b1;
        strb.rxIrqOk  = 1'b1;
        txEnable      = 1'b1;
      end
      MODE_LISTEN: begin
        strb.listenChk = 1'b1;
        strb.rxIrqOk   = 1'b1;
        errCntFreeze   = 1'b1;
        errPassive     = 1'b1;
      end
      MODE_LOOP: begin
        strb.loopSel   = 1'b1;
        strb.ackIgnore = 1'b1;
        strb.txIrqOk   = 1'b1;
        strb.rxIrqOk   = 1'b1;
        txEnable       = 1'b1;
      end
      MODE_FRZ: begin
        strb.hold    = 1'b1;
        engHold      = 1'b1;
        errCntFreeze = 1'b1;
      end
      default: begin
        strb.hold = 1'b1;
        engHold   = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/can_mode_dpath.sv
module can_mode_dpath
  import can_mode_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  pathStrb_t strb,
  input  logic      rxPin,
  input  logic      engTxBit,
  input  logic      ackSlot,
  input  logic      txDone,
  input  logic      rxDone,
  output logic      txPin,
  output logic      engRxBit,
  output logic      bit0Err,
  output logic      txIrq,
  output logic      rxIrq
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic rxSync;
  logic ackSeenQ;
  logic loopBit;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[g] <= 1'b1;
          else       syncQ[g] <= rxPin;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[g] <= 1'b1;
          else       syncQ[g] <= syncQ[g-1];
        end
      end
    end
  endgenerate

  assign rxSync = syncQ[LAST];

  // remembers whether the last ACK slot was driven dominant
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        ackSeenQ <= 1'b0;
    else if (ackSlot) ackSeenQ <= ~rxSync;
  end

  assign loopBit  = (ackSlot && strb.ackIgnore) ? 1'b0 : engTxBit;
  assign engRxBit = strb.hold ? 1'b1 : (strb.loopSel ? loopBit : rxSync);
  assign txPin    = strb.pinDrive ? engTxBit : 1'b1;
  assign bit0Err  = strb.listenChk & ackSlot & rxSync;
  assign txIrq    = txDone & strb.txIrqOk;
  assign rxIrq    = rxDone & strb.rxIrqOk & (~strb.listenChk | ackSeenQ);

endmodule

// File: rtl/can_mode_mgr.sv
module can_mode_mgr
  import can_mode_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic freezeEn,
  input  logic haltReq,
  input  logic dbgReq,
  input  logic listenOnly,
  input  logic loopBack,
  input  logic disableReq,
  input  logic rxPin,
  input  logic engTxBit,
  input  logic ackSlot,
  input  logic busIdle,
  input  logic txDone,
  input  logic rxDone,
  output logic txPin,
  output logic engRxBit,
  output logic txEnable,
  output logic errCntFreeze,
  output logic errPassive,
  output logic engHold,
  output logic freezeAck,
  output logic bit0Err,
  output logic txIrq,
  output logic rxIrq
);

  opMode_e   modeQ;
  pathStrb_t strb;

  can_mode_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .freezeEn(freezeEn), .haltReq(haltReq),
    .dbgReq(dbgReq), .listenOnly(listenOnly), .loopBack(loopBack),
    .disableReq(disableReq), .busIdle(busIdle), .modeQ(modeQ),
    .strb(strb), .txEnable(txEnable), .errCntFreeze(errCntFreeze),
    .errPassive(errPassive), .engHold(engHold), .freezeAck(freezeAck)
  );

  can_mode_dpath #(.SYNC_STAGES(SYNC_STAGES)) i_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .rxPin(rxPin),
    .engTxBit(engTxBit), .ackSlot(ackSlot), .txDone(txDone),
    .rxDone(rxDone), .txPin(txPin), .engRxBit(engRxBit),
    .bit0Err(bit0Err), .txIrq(txIrq), .rxIrq(rxIrq)
  );

endmodule

// File: rtl/can_mode_chk.sv
module can_mode_chk
  import can_mode_pkg::*;
(
  input logic    clk,
  input logic    rstN,
  input logic    freezeEn,
  input logic    haltReq,
  input logic    dbgReq,
  input logic    busIdle,
  input logic    ackSlot,
  input logic    engTxBit,
  input logic    txPin,
  input logic    engRxBit,
  input logic    txEnable,
  input logic    engHold,
  input logic    freezeAck,
  input logic    bit0Err,
  input logic    txIrq,
  input logic    rxIrq,
  input opMode_e modeQ
);

  // R1
  freeze_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (freezeEn && (haltReq || dbgReq)) |=> (modeQ == MODE_FRZ));

  // R2
  freeze_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    freezeAck |-> (modeQ == MODE_FRZ && engHold));

  // R4
  boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busIdle && !(freezeEn && (haltReq || dbgReq))) |=> $stable(modeQ));

  // R5
  pin_recessive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ != MODE_NORM) |-> txPin);

  // R6
  bit0_scope_chk: assert property (@(posedge clk) disable iff (!rstN)
    bit0Err |-> (modeQ == MODE_LISTEN && ackSlot));

  // R8
  loop_path_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_LOOP && !ackSlot) |-> (engRxBit == engTxBit));

  // R11
  disable_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_DIS) |-> (!txIrq && !rxIrq && !bit0Err && !freezeAck && !txEnable));

endmodule

bind can_mode_mgr can_mode_chk i_chk (
  .clk(clk), .rstN(rstN), .freezeEn(freezeEn), .haltReq(haltReq),
  .dbgReq(dbgReq), .busIdle(busIdle), .ackSlot(ackSlot),
  .engTxBit(engTxBit), .txPin(txPin), .engRxBit(engRxBit),
  .txEnable(txEnable), .engHold(engHold), .freezeAck(freezeAck),
  .bit0Err(bit0Err), .txIrq(txIrq), .rxIrq(rxIrq), .modeQ(modeQ)
);

// File: tb/test_can_mode_mgr.sv
module test_can_mode_mgr;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic freezeEn = 0, haltReq = 0, dbgReq = 0, listenOnly = 0, loopBack = 0;
  logic disableReq = 0, rxPin = 1, engTxBit = 1, ackSlot = 0, busIdle = 0;
  logic txDone = 0, rxDone = 0;
  logic txPin, engRxBit, txEnable, errCntFreeze, errPassive, engHold;
  logic freezeAck, bit0Err, txIrq, rxIrq;

  always #10 clk = ~clk;

  can_mode_mgr i_can_mode_mgr (.*);

  typedef enum int {S_TXPIN, S_RXBIT, S_TXEN, S_ERRFRZ, S_PASSIVE, S_HOLD,
                    S_FACK, S_BIT0, S_TXIRQ, S_RXIRQ} sel_e;
  typedef struct {
    string tag;
    sel_e  sel;
    logic  exp;
  } item_t;

  item_t queueQ[$];
  event  sampleEv;
  int    total = 0;
  int    fails = 0;
  bit    done = 0;

  function automatic logic pick(sel_e s);
    case (s)
      S_TXPIN:   return txPin;
      S_RXBIT:   return engRxBit;
      S_TXEN:    return txEnable;
      S_ERRFRZ:  return errCntFreeze;
      S_PASSIVE: return errPassive;
      S_HOLD:    return engHold;
      S_FACK:    return freezeAck;
      S_BIT0:    return bit0Err;
      S_TXIRQ:   return txIrq;
      default:   return rxIrq;
    endcase
  endfunction

  // monitor: pops expectations and compares
  initial begin
    forever begin
      @(sampleEv);
      #1;
      while (queueQ.size() > 0) begin
        item_t it;
        logic  act;
        it  = queueQ.pop_front();
        act = pick(it.sel);
        total++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s %s actual=%b expected=%b", it.tag, it.sel.name(), act, it.exp);
        end
      end
    end
  end

  task automatic expect1(string tag, sel_e s, logic e);
    item_t it;
    it.tag = tag; it.sel = s; it.exp = e;
    queueQ.push_back(it);
  endtask

  task automatic sample();
    #1;
    -> sampleEv;
    #3;
  endtask

  task automatic edge1();
    @(negedge clk);
  endtask

  task automatic boundary();
    busIdle = 1'b1;
    edge1();
    busIdle = 1'b0;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) edge1();
    rstN = 1'b1;
    edge1();
    // R11 reset state is disable
    expect1("R11", S_TXPIN, 1); expect1("R11", S_RXBIT, 1);
    expect1("R11", S_HOLD, 1);  expect1("R11", S_TXEN, 0);
    expect1("R11", S_FACK, 0);  expect1("R11", S_ERRFRZ, 0);
    sample();

    // R12 normal
    boundary();
    engTxBit = 0;
    expect1("R12", S_TXEN, 1); expect1("R12", S_HOLD, 0);
    expect1("R12", S_TXPIN, 0);
    sample();
    rxPin = 0;
    edge1();
    expect1("R12", S_RXBIT, 1);
    sample();
    edge1();
    expect1("R12", S_RXBIT, 0);
    txDone = 1; rxDone = 1;
    expect1("R12", S_TXIRQ, 1); expect1("R12", S_RXIRQ, 1);
    sample();
    txDone = 0; rxDone = 0;

    // R4 no change without bus idle
    listenOnly = 1;
    edge1();
    expect1("R4", S_TXEN, 1);
    sample();
    boundary();
    // R5 listen-only
    expect1("R5", S_TXEN, 0); expect1("R5", S_TXPIN, 1);
    expect1("R5", S_ERRFRZ, 1); expect1("R5", S_PASSIVE, 1);
    sample();

    // R6 recessive ACK slot
    rxPin = 1;
    edge1(); edge1();
    ackSlot = 1;
    expect1("R6", S_BIT0, 1); expect1("R6", S_ERRFRZ, 1);
    sample();
    edge1();
    ackSlot = 0; rxDone = 1; txDone = 1;
    expect1("R6", S_BIT0, 0);
    expect1("R7", S_RXIRQ, 0); expect1("R7", S_TXIRQ, 0);
    sample();
    rxDone = 0; txDone = 0;
    rxPin = 0;
    edge1(); edge1();
    ackSlot = 1;
    expect1("R6", S_BIT0, 0);
    sample();
    edge1();
    ackSlot = 0; rxDone = 1;
    expect1("R7", S_RXIRQ, 1);
    sample();
    rxDone = 0;

    // R10 loop wins over listen; R8 loop path
    loopBack = 1;
    boundary();
    rxPin = 1; engTxBit = 0;
    edge1(); edge1();
    expect1("R10", S_TXEN, 1); expect1("R10", S_TXPIN, 1);
    expect1("R8", S_RXBIT, 0);
    sample();
    engTxBit = 1; rxPin = 0;
    edge1(); edge1();
    expect1("R8", S_RXBIT, 1); expect1("R8", S_TXPIN, 1);
    sample();
    // R9 ACK ignored, both interrupts pass
    ackSlot = 1; txDone = 1; rxDone = 1;
    expect1("R9", S_RXBIT, 0); expect1("R9", S_TXIRQ, 1);
    expect1("R9", S_RXIRQ, 1); expect1("R9", S_BIT0, 0);
    sample();
    ackSlot = 0; txDone = 0; rxDone = 0;

    // R1 halt without enable ignored
    haltReq = 1;
    edge1();
    expect1("R1", S_HOLD, 0);
    sample();
    freezeEn = 1;
    edge1();
    expect1("R1", S_HOLD, 1); expect1("R2", S_FACK, 0);
    sample();
    boundary();
    expect1("R2", S_FACK, 1);
    txDone = 1; rxDone = 1;
    expect1("R3", S_RXBIT, 1); expect1("R3", S_TXEN, 0);
    expect1("R3", S_TXIRQ, 0); expect1("R3", S_RXIRQ, 0);
    expect1("R3", S_ERRFRZ, 1); expect1("R3", S_TXPIN, 1);
    sample();
    txDone = 0; rxDone = 0;
    haltReq = 0; loopBack = 0; listenOnly = 0;
    boundary();
    expect1("R2", S_FACK, 0); expect1("R4", S_TXEN, 1);
    expect1("R4", S_HOLD, 0);
    sample();

    // R1 debug request path, entered while bus busy
    dbgReq = 1;
    edge1();
    expect1("R1", S_HOLD, 1);
    sample();

    // R11 disable after freeze released
    dbgReq = 0; disableReq = 1; loopBack = 1;
    boundary();
    txDone = 1; rxDone = 1; engTxBit = 0;
    expect1("R11", S_HOLD, 1); expect1("R11", S_TXIRQ, 0);
    expect1("R11", S_RXIRQ, 0); expect1("R11", S_TXPIN, 1);
    expect1("R11", S_PASSIVE, 0); expect1("R11", S_FACK, 0);
    sample();

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule